// File: doc/BRIEF.md
# ADC Bus-Side Conversion Controller

This block is the synchronous control logic on the bus side of an 8-bit sampling converter. A host drives three control lines. `rw_sel` selects the operation: low asks for a conversion, high asks for a read. `ce_n` and `cs_n` are active-low enables. When all three lines are low long enough, the block starts a conversion and raises `busy` for a programmable number of clock cycles. When the timer runs out, it captures the value on `sample_in` into a result register.

A read happens when `rw_sel` is high and both enables are low while no conversion is running. After a fixed access delay the block turns on the data bus. It turns the bus off a fixed number of cycles after either enable is raised. Nanosecond timing is expressed as clock-cycle parameters.

The block supports stand-alone use with `ce_n` and `cs_n` tied together. Holding all three lines low gives back-to-back conversions. Raising `rw_sel` while `busy` is high ends the series after the current conversion, and the block then presents that conversion's result as a read. `sample_in` is a plain level port with no handshake: the block samples it on the single cycle the conversion ends, so the source must hold it valid then.

Top module: `adc_bus_ctrl`

## Requirements
- R1: Reset state. While `rst` is high, and right after it, `busy` and `bus_oe` are 0 and `bus_data` is 0. A read issued after reset returns 0x00.
- R2: Start timing. The order in which the three controls fall does not matter. `busy` rises exactly SYNC_STAGES+1+WR_CYC rising edges after the last of the three goes low (18 edges with the defaults).
- R3: Minimum low time. An all-low window lasting WR_CYC-1 clock cycles never raises `busy`. A window of exactly WR_CYC cycles does raise it.
- R4: Conversion length and capture. `busy` stays high for exactly CONV_CYC cycles. On the edge where it falls, the result register loads `sample_in`. The result changes at no other time.
- R5: Lockout. Start requests made while `busy` is high are ignored. If the controls are released before the conversion ends, `busy` falls on schedule and stays low afterwards.
- R6: Continuous mode. If all three controls stay low, `busy` is low for exactly one cycle and then a new conversion starts.
- R7: `bus_oe` is never 1 while `busy` is 1.
- R8: Access delay. `bus_oe` rises SYNC_STAGES+ACC_CYC edges after a read condition (`rw_sel`=1, `ce_n`=0, `cs_n`=0) appears on idle ports. If the read condition is already present when `busy` falls, `bus_oe` rises ACC_CYC edges after that fall.
- R9: End of read. `bus_oe` falls SYNC_STAGES+OFF_CYC edges after `ce_n` or `cs_n` goes high. While `bus_oe` is 1, `bus_data` equals the last captured result.
- R10: Float. Whenever `bus_oe` is 0, `bus_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rw_sel | input | 1 | 1 = read, 0 = convert request (asynchronous) |
| ce_n | input | 1 | Active-low chip enable (asynchronous) |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sample_in | input | DATA_W | Converter result, captured at end of conversion |
| busy | output | 1 | High while a conversion runs |
| bus_oe | output | 1 | Data bus driver enable |
| bus_data | output | DATA_W | Data bus value, zero when not enabled |

## Verification
The hardest case to reach from the ports is the edge of the qualifier threshold. The three controls must be low together for exactly WR_CYC-1 cycles or exactly WR_CYC cycles, after they have fallen one by one in some order. The bench drives the controls on the falling clock edge and releases them after a counted number of rising edges, so the window length is exact. It then runs both lengths, and draws random fall orders and gaps from a seeded generator. Lockout is reached by re-qualifying a request inside a running conversion and releasing it before the timer expires.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  localparam int CTRL_W = 3;
  typedef struct packed {
    logic rw;
    logic ce_n;
    logic cs_n;
  } ctrl_t;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '1;
    else     pipe[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= '1;
      else     pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/adc_start_qual.sv
module adc_start_qual #(
  parameter int WR_CYC = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic qualified
);
  localparam int CW = $clog2(WR_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !req)              cnt <= '0;
    else if (cnt != CW'(WR_CYC))  cnt <= cnt + 1'b1;
  end

  assign qualified = (cnt == CW'(WR_CYC));

  AST_QUAL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(qualified) |-> $past(req)); // R3
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int DATA_W   = 8,
  parameter int CONV_CYC = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              qualified,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy,
  output logic [DATA_W-1:0] result
);
  localparam int TW = $clog2(CONV_CYC + 1);
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      tcnt   <= '0;
      result <= '0;
    end else if (!busy) begin
      if (qualified) begin
        busy <= 1'b1;
        tcnt <= '0;
      end
    end else if (tcnt == TW'(CONV_CYC - 1)) begin
      busy   <= 1'b0;
      result <= sample_in;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(qualified)); // R2
  AST_RESULT_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> $stable(result)); // R4
endmodule

// File: rtl/adc_read_path.sv
module adc_read_path #(
  parameter int DATA_W  = 8,
  parameter int ACC_CYC = 10,
  parameter int OFF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              busy,
  input  logic [DATA_W-1:0] result,
  output logic              oe,
  output logic [DATA_W-1:0] data
);
  localparam int AW = $clog2(ACC_CYC + 1);
  localparam int OW = $clog2(OFF_CYC + 1);
  logic          rd_ok;
  logic [AW-1:0] acnt;
  logic [OW-1:0] ocnt;

  assign rd_ok = rd_req & ~busy;

  always_ff @(posedge clk) begin
    if (rst || !rd_ok)              acnt <= '0;
    else if (acnt != AW'(ACC_CYC))  acnt <= acnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe   <= 1'b0;
      ocnt <= '0;
    end else if (rd_ok) begin
      ocnt <= '0;
      if (acnt == AW'(ACC_CYC - 1)) oe <= 1'b1;
    end else if (oe) begin
      if (ocnt == OW'(OFF_CYC - 1)) begin
        oe   <= 1'b0;
        ocnt <= '0;
      end else begin
        ocnt <= ocnt + 1'b1;
      end
    end
  end

  assign data = oe ? result : '0;

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(rd_ok)); // R8
  AST_OE_DROP_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(oe) |-> $past(!rd_ok)); // R9
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WR_CYC      = 15,
  parameter int CONV_CYC    = 500,
  parameter int ACC_CYC     = 10,
  parameter int OFF_CYC     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rw_sel,
  input  logic              ce_n,
  input  logic              cs_n,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_data
);
  import adc_bus_pkg::*;

  ctrl_t             raw, syn;
  logic [CTRL_W-1:0] syn_bits;
  logic              conv_req, rd_req, qualified;
  logic [DATA_W-1:0] result;

  assign raw = '{rw: rw_sel, ce_n: ce_n, cs_n: cs_n};

  adc_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn_bits)
  );
  assign syn = ctrl_t'(syn_bits);

  assign conv_req = ~syn.rw & ~syn.ce_n & ~syn.cs_n;
  assign rd_req   =  syn.rw & ~syn.ce_n & ~syn.cs_n;

  adc_start_qual #(.WR_CYC(WR_CYC)) u_qual (
    .clk(clk), .rst(rst), .req(conv_req), .qualified(qualified)
  );

  adc_conv_timer #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) u_timer (
    .clk(clk), .rst(rst), .qualified(qualified), .sample_in(sample_in),
    .busy(busy), .result(result)
  );

  adc_read_path #(.DATA_W(DATA_W), .ACC_CYC(ACC_CYC), .OFF_CYC(OFF_CYC)) u_read (
    .clk(clk), .rst(rst), .rd_req(rd_req), .busy(busy), .result(result),
    .oe(bus_oe), .data(bus_data)
  );

  AST_NO_OE_DURING_CONV: assert property (@(posedge clk) disable iff (rst)
    busy |-> !bus_oe); // R7
  AST_FLOAT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_data == '0)); // R10
endmodule

// File: tb/adc_bus_ctrl_bench.sv
module adc_bus_ctrl_bench;
  localparam int W_CYC = 15;
  localparam int C_CYC = 500;
  localparam int A_CYC = 10;
  localparam int O_CYC = 2;
  localparam int SYNC  = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rw_sel = 1'b1, ce_n = 1'b1, cs_n = 1'b1;
  logic [7:0] sample_in = '0;
  logic       busy, bus_oe;
  logic [7:0] bus_data;

  int total = 0;
  int bad = 0;
  int oe_busy_viol = 0;
  int float_viol = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_bus_ctrl u_adc_bus_ctrl (
    .clk(clk), .rst(rst), .rw_sel(rw_sel), .ce_n(ce_n), .cs_n(cs_n),
    .sample_in(sample_in), .busy(busy), .bus_oe(bus_oe), .bus_data(bus_data)
  );

  always @(negedge clk) if (!rst) begin
    if (busy && bus_oe) oe_busy_viol++;
    if (!bus_oe && bus_data != 8'h00) float_viol++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic probe(input int which);
    return (which == 0) ? busy : bus_oe;
  endfunction

  // counts rising edges until the probed output reaches lvl (sampled at negedge)
  task automatic wait_for(input int which, input logic lvl, input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (probe(which) !== lvl && n < limit);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // all-low window of len cycles; returns edge index of busy rise, 0 if none
  task automatic pulse(input int len, output int rise_at);
    rise_at = 0;
    rw_sel = 0; ce_n = 0; cs_n = 0;
    for (int n = 1; n <= W_CYC + 12; n++) begin
      @(posedge clk); @(negedge clk);
      if (n == len) begin rw_sel = 1; ce_n = 1; cs_n = 1; end
      if (busy && rise_at == 0) rise_at = n;
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'h5EED_0A67));
    idle(4);
    chk("R1 busy in reset", busy, 0);
    chk("R1 oe in reset", bus_oe, 0);
    @(negedge clk); rst = 0;
    chk("R1 busy after reset", busy, 0);
    chk("R1 data after reset", bus_data, 0);

    // read after reset
    ce_n = 0; cs_n = 0;
    wait_for(1, 1'b1, 100, n);
    chk("R8 access delay idle read", n, SYNC + A_CYC);
    chk("R1 reset result read", bus_data, 8'h00);
    ce_n = 1;
    wait_for(1, 1'b0, 100, n);
    chk("R9 end of read delay", n, SYNC + O_CYC);
    cs_n = 1; idle(3);

    // continuous mode then stand-alone read
    sample_in = 8'hA5;
    rw_sel = 0; ce_n = 0; cs_n = 0;
    wait_for(0, 1'b1, 100, n);
    chk("R2 start delay", n, SYNC + 1 + W_CYC);
    wait_for(0, 1'b0, 2 * C_CYC, n);
    chk("R4 conversion length", n, C_CYC);
    wait_for(0, 1'b1, 100, n);
    chk("R6 continuous restart gap", n, 1);
    sample_in = 8'h3C;
    rw_sel = 1;
    wait_for(0, 1'b0, 2 * C_CYC, n);
    chk("R4 second conversion length", n, C_CYC);
    wait_for(1, 1'b1, 100, n);
    chk("R8 access after conversion", n, A_CYC);
    chk("R4 captured sample", bus_data, 8'h3C);
    idle(5);
    chk("R9 data held during read", bus_data, 8'h3C);
    cs_n = 1;
    wait_for(1, 1'b0, 100, n);
    chk("R9 end of read via cs", n, SYNC + O_CYC);
    ce_n = 1; idle(3);

    // threshold boundary
    pulse(W_CYC - 1, n);
    chk("R3 short window no start", n, 0);
    pulse(W_CYC, n);
    chk("R3 exact window starts", n, W_CYC + SYNC + 1);
    wait_for(0, 1'b0, 2 * C_CYC, n);
    idle(3);

    // lockout: qualify again inside conversion, release before end
    sample_in = 8'h5A;
    rw_sel = 0; ce_n = 0; cs_n = 0;
    wait_for(0, 1'b1, 100, n);
    idle(50);
    rw_sel = 1; idle(4);
    rw_sel = 0; idle(W_CYC + 10);
    rw_sel = 1; ce_n = 1; cs_n = 1;
    wait_for(0, 1'b0, 2 * C_CYC, n);
    chk("R5 conversion ends on schedule", n, C_CYC - 50 - 4 - W_CYC - 10);
    wait_for(0, 1'b1, W_CYC + 10, n);
    chk("R5 no restart after lockout", busy, 0);

    // random orderings and samples
    for (int it = 0; it < 6; it++) begin
      logic [7:0] s;
      int ord;
      s = 8'($urandom);
      ord = $urandom % 6;
      sample_in = s;
      for (int k = 0; k < 3; k++) begin
        int sel;
        case (ord)
          0: sel = k;
          1: sel = (k == 0) ? 0 : (k == 1) ? 2 : 1;
          2: sel = (k == 0) ? 1 : (k == 1) ? 0 : 2;
          3: sel = (k == 0) ? 1 : (k == 1) ? 2 : 0;
          4: sel = (k == 0) ? 2 : (k == 1) ? 0 : 1;
          default: sel = 2 - k;
        endcase
        if (sel == 0) rw_sel = 0; else if (sel == 1) ce_n = 0; else cs_n = 0;
        if (k < 2) idle($urandom % 5);
      end
      wait_for(0, 1'b1, 100, n);
      chk("R2 random order start delay", n, SYNC + 1 + W_CYC);
      rw_sel = 1;
      wait_for(0, 1'b0, 2 * C_CYC, n);
      chk("R4 random conversion length", n, C_CYC);
      wait_for(1, 1'b1, 100, n);
      chk("R8 random access", n, A_CYC);
      chk("R4 random captured sample", bus_data, s);
      if ($urandom % 2) ce_n = 1; else cs_n = 1;
      wait_for(1, 1'b0, 100, n);
      chk("R9 random end of read", n, SYNC + O_CYC);
      rw_sel = 1; ce_n = 1; cs_n = 1;
      idle(2 + $urandom % 4);
    end

    chk("R7 oe while busy count", oe_busy_viol, 0);
    chk("R10 float violations", float_viol, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule